// File: doc/BRIEF.md
# Read Request Header Formatter

This block sits between a byte-addressed local bus slave port and the transmit side of a PCIe endpoint. It takes a read request, given as a 32-bit byte address and a byte count from 1 to 64, and turns it into the fields of one memory-read request header. Those fields are a doubleword-aligned address, a Length in doublewords, a first-DW byte enable, a last-DW byte enable and a transaction tag. Requests come in through a valid/ready handshake. Headers go out through a single registered output stage with its own valid/ready handshake.

A static configuration input picks one of two modes. In exact mode, the byte enables mark only the bytes that were asked for. In widened mode, every read becomes whole doublewords with all bytes enabled. That avoids a known fault with unaligned accesses, but a narrow read then also reads the neighbouring bytes of the same doubleword at the link partner. This can matter when a read has side effects, such as popping a FIFO. A request whose bytes would run past a 4 KB page boundary is consumed without producing a header, and an error flag is pulsed for one cycle.

Top module: `rd_hdr_fmt`

## Requirements
- R1: `hdr_dw_cnt_o` equals the number of doublewords the byte span touches, (addr[1:0] + count + 3) >> 2, in both modes. For example, 64 bytes at offset 3 give 17.
- R2: `hdr_dw_addr_o` carries request address bits [31:2], so the header address is always doubleword-aligned.
- R3: In exact mode (`widen_i` = 0), bit i of `hdr_fbe_o` is set when byte lane i of the first doubleword is requested. A 1-byte read at 0x1 gives 4'b0010, and a 2-byte read at 0x2 gives 4'b1100.
- R4: In widened mode (`widen_i` = 1), `hdr_fbe_o` is 4'hF for any offset and size. A 1-byte read at 0x1 gives Length 1, doubleword address 0 and first enable 4'hF.
- R5: `hdr_lbe_o` is 4'b0000 when Length is 1. Otherwise, in exact mode bit i is set for lanes 0 up to the lane of the last requested byte, and in widened mode it is 4'hF.
- R6: Every accepted request that does not cross a page boundary yields exactly one header, one cycle after acceptance. Three widened 1-byte reads at 0x1, 0x2 and 0x3 give three identical headers for doubleword address 0.
- R7: `hdr_tag_o` is 0 after reset. It rises by one on each cycle where `hdr_valid_o` and `hdr_ready_i` are both high, and wraps from 31 to 0.
- R8: A request where addr[11:0] + count > 4096 is accepted but gives no header. `err_page_o` is high for exactly the one cycle after its acceptance.
- R9: `req_ready_o` is high exactly when the output stage is empty or is being drained in the same cycle.
- R10: While `hdr_valid_o` is high and `hdr_ready_i` is low, `hdr_valid_o` stays high and all header fields hold their values on the next cycle.
- R11: After reset, `hdr_valid_o`, `err_page_o` and `hdr_tag_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| widen_i | input | 1 | 1 selects widened full-doubleword reads |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_addr_i | input | 32 | Request byte address |
| req_bytes_i | input | 7 | Request byte count, 1 to 64 |
| hdr_valid_o | output | 1 | Header fields valid |
| hdr_ready_i | input | 1 | Downstream takes the header |
| hdr_dw_addr_o | output | 30 | Address bits [31:2] |
| hdr_dw_cnt_o | output | 5 | Length in doublewords |
| hdr_fbe_o | output | 4 | First-DW byte enable |
| hdr_lbe_o | output | 4 | Last-DW byte enable |
| hdr_tag_o | output | 5 | Transaction tag |
| err_page_o | output | 1 | One-cycle pulse for a dropped page-crossing request |

## Verification
The assertions assume that the byte count is never 0 whenever a request is offered, and that `widen_i` changes only while no request is being accepted, so each header reflects one mode. The stimulus draws counts from 1 to 64 only. It changes the mode between phases, while the request valid is low. It includes addresses near the top of a 4 KB page, so that both the crossing and the exact-fit cases occur. Output ready is driven at random so that the stall hold rule and the drain-while-accept path are both exercised.

// File: rtl/rd_hdr_pkg.sv
package rd_hdr_pkg;
    localparam int RHF_ADDR_W = 32;
    localparam int RHF_MAX_BYTES = 64;
    localparam int RHF_CNT_W = $clog2(RHF_MAX_BYTES + 1);
    localparam int RHF_DWC_W = $clog2(RHF_MAX_BYTES / 4 + 2);
    localparam int RHF_TAG_W = 5;
    localparam int RHF_PAGE_W = 12;

    typedef struct packed {
        logic                    vld;
        logic [RHF_ADDR_W-3:0]   dw_addr;
        logic [RHF_DWC_W-1:0]    dw_cnt;
        logic [3:0]              fbe;
        logic [3:0]              lbe;
        logic                    widened;
        logic                    err;
    } rhf_stage_t;
endpackage

// File: rtl/rhf_field_calc.sv
module rhf_field_calc #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 7,
    parameter int DWC_W  = 5,
    parameter int PAGE_W = 12
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              widen_i,
    output logic [ADDR_W-3:0] dw_addr_o,
    output logic [DWC_W-1:0]  dw_cnt_o,
    output logic [3:0]        fbe_o,
    output logic [3:0]        lbe_o,
    output logic              cross_o
);
    localparam int SPAN_W = CNT_W + 2;
    localparam int PGX_W  = PAGE_W + 1;
    localparam logic [PGX_W-1:0] PAGE_SIZE = PGX_W'(1) << PAGE_W;

    logic [1:0]        off;
    logic [1:0]        end_lane;
    logic [SPAN_W-1:0] span;
    logic [SPAN_W-1:0] span_last;
    logic [SPAN_W-1:0] span_up;
    logic              single_dw;
    logic [3:0]        head_mask;
    logic [3:0]        tail_mask;
    logic [PGX_W-1:0]  page_end;

    always_comb begin
        off       = addr_i[1:0];
        span      = SPAN_W'(off) + SPAN_W'(cnt_i);
        span_last = span - SPAN_W'(1);
        span_up   = span + SPAN_W'(3);
        end_lane  = span_last[1:0];
        single_dw = (span <= SPAN_W'(4));
        head_mask = 4'hF << off;
        tail_mask = 4'hF >> (2'd3 - end_lane);

        dw_addr_o = addr_i[ADDR_W-1:2];
        dw_cnt_o  = DWC_W'(span_up >> 2);

        if (widen_i) begin
            fbe_o = 4'hF;
            lbe_o = single_dw ? 4'h0 : 4'hF;
        end else begin
            fbe_o = single_dw ? (head_mask & tail_mask) : head_mask;
            lbe_o = single_dw ? 4'h0 : tail_mask;
        end

        page_end = PGX_W'(addr_i[PAGE_W-1:0]) + PGX_W'(cnt_i);
        cross_o  = (page_end > PAGE_SIZE);
    end
endmodule

// File: rtl/rhf_tag_ctr.sv
module rhf_tag_ctr #(
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [TAG_W-1:0] tag_o
);
    logic [TAG_W-1:0] tag_d, tag_q;

    always_comb begin
        tag_d = tag_q;
        if (adv_i) tag_d = tag_q + TAG_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tag_q <= '0;
        else        tag_q <= tag_d;
    end

    assign tag_o = tag_q;

    // R7: one step per downstream handshake, wrapping naturally
    a_r7_tag_step: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |=> tag_o == TAG_W'($past(tag_o) + TAG_W'(1)));
    a_r7_tag_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(tag_o));
endmodule

// File: rtl/rd_hdr_fmt.sv
module rd_hdr_fmt
    import rd_hdr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  widen_i,
    input  logic                  req_valid_i,
    output logic                  req_ready_o,
    input  logic [RHF_ADDR_W-1:0] req_addr_i,
    input  logic [RHF_CNT_W-1:0]  req_bytes_i,
    output logic                  hdr_valid_o,
    input  logic                  hdr_ready_i,
    output logic [RHF_ADDR_W-3:0] hdr_dw_addr_o,
    output logic [RHF_DWC_W-1:0]  hdr_dw_cnt_o,
    output logic [3:0]            hdr_fbe_o,
    output logic [3:0]            hdr_lbe_o,
    output logic [RHF_TAG_W-1:0]  hdr_tag_o,
    output logic                  err_page_o
);
    rhf_stage_t st_d, st_q;

    logic [RHF_ADDR_W-3:0] c_dw_addr;
    logic [RHF_DWC_W-1:0]  c_dw_cnt;
    logic [3:0]            c_fbe;
    logic [3:0]            c_lbe;
    logic                  c_cross;
    logic                  in_fire;
    logic                  out_fire;

    rhf_field_calc #(
        .ADDR_W (RHF_ADDR_W),
        .CNT_W  (RHF_CNT_W),
        .DWC_W  (RHF_DWC_W),
        .PAGE_W (RHF_PAGE_W)
    ) u_calc (
        .addr_i    (req_addr_i),
        .cnt_i     (req_bytes_i),
        .widen_i   (widen_i),
        .dw_addr_o (c_dw_addr),
        .dw_cnt_o  (c_dw_cnt),
        .fbe_o     (c_fbe),
        .lbe_o     (c_lbe),
        .cross_o   (c_cross)
    );

    rhf_tag_ctr #(.TAG_W(RHF_TAG_W)) u_tag (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (out_fire),
        .tag_o (hdr_tag_o)
    );

    assign out_fire    = st_q.vld & hdr_ready_i;
    assign req_ready_o = ~st_q.vld | hdr_ready_i;
    assign in_fire     = req_valid_i & req_ready_o;

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (out_fire) st_d.vld = 1'b0;
        if (in_fire) begin
            if (c_cross) begin
                st_d.err = 1'b1;
            end else begin
                st_d.vld     = 1'b1;
                st_d.dw_addr = c_dw_addr;
                st_d.dw_cnt  = c_dw_cnt;
                st_d.fbe     = c_fbe;
                st_d.lbe     = c_lbe;
                st_d.widened = widen_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hdr_valid_o   = st_q.vld;
    assign hdr_dw_addr_o = st_q.dw_addr;
    assign hdr_dw_cnt_o  = st_q.dw_cnt;
    assign hdr_fbe_o     = st_q.fbe;
    assign hdr_lbe_o     = st_q.lbe;
    assign err_page_o    = st_q.err;

    // R10: stalled header holds
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid_o && !hdr_ready_i |=> hdr_valid_o && $stable(hdr_dw_addr_o)
            && $stable(hdr_dw_cnt_o) && $stable(hdr_fbe_o) && $stable(hdr_lbe_o)
            && $stable(hdr_tag_o));
    // R8: error pulse only follows an accepted request
    a_r8_err_src: assert property (@(posedge clk) disable iff (!rst_n)
        err_page_o |-> $past(req_valid_i && req_ready_o));
    // R8: a dropped request never fills an empty stage
    a_r8_no_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        err_page_o && !$past(hdr_valid_o) |-> !hdr_valid_o);
    // R6: a new header appears only after an acceptance
    a_r6_one_hdr: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hdr_valid_o) |-> $past(req_valid_i && req_ready_o));
    // R4: widened headers carry full first enables
    a_r4_full_fbe: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid_o && st_q.widened |-> hdr_fbe_o == 4'hF);
    // R5: single-doubleword headers have an empty last enable
    a_r5_single_lbe: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid_o && hdr_dw_cnt_o == RHF_DWC_W'(1) |-> hdr_lbe_o == 4'h0);
    // R1: Length is never zero on a valid header
    a_r1_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid_o |-> hdr_dw_cnt_o != '0);
endmodule

// File: tb/test_rd_hdr_fmt.sv
module test_rd_hdr_fmt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        widen_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic        req_ready_o;
    logic [31:0] req_addr_i = '0;
    logic [6:0]  req_bytes_i = 7'd1;
    logic        hdr_valid_o;
    logic        hdr_ready_i = 1'b0;
    logic [29:0] hdr_dw_addr_o;
    logic [4:0]  hdr_dw_cnt_o;
    logic [3:0]  hdr_fbe_o;
    logic [3:0]  hdr_lbe_o;
    logic [4:0]  hdr_tag_o;
    logic        err_page_o;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    bit          m_vld = 0;
    bit          m_err = 0;
    int unsigned m_tag = 0;
    int unsigned m_addr = 0;
    int unsigned m_cnt = 0;
    int unsigned m_fbe = 0;
    int unsigned m_lbe = 0;

    always #5 clk = ~clk;

    rd_hdr_fmt i_rd_hdr_fmt (
        .clk(clk), .rst_n(rst_n), .widen_i(widen_i),
        .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
        .req_addr_i(req_addr_i), .req_bytes_i(req_bytes_i),
        .hdr_valid_o(hdr_valid_o), .hdr_ready_i(hdr_ready_i),
        .hdr_dw_addr_o(hdr_dw_addr_o), .hdr_dw_cnt_o(hdr_dw_cnt_o),
        .hdr_fbe_o(hdr_fbe_o), .hdr_lbe_o(hdr_lbe_o),
        .hdr_tag_o(hdr_tag_o), .err_page_o(err_page_o)
    );

    task automatic cmp(input string req, input string what,
                       input int unsigned act, input int unsigned exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_outputs();
        cmp("R11/R6", "hdr_valid", hdr_valid_o, m_vld);
        cmp("R8", "err_page", err_page_o, m_err);
        cmp("R7", "tag", hdr_tag_o, m_tag);
        if (m_vld) begin
            cmp("R2", "dw_addr", hdr_dw_addr_o, m_addr);
            cmp("R1", "dw_cnt", hdr_dw_cnt_o, m_cnt);
            cmp("R3/R4", "fbe", hdr_fbe_o, m_fbe);
            cmp("R5", "lbe", hdr_lbe_o, m_lbe);
        end
    endtask

    // one clock: entered just after a negedge, leaves after the next negedge
    task automatic cycle(input bit v, input int unsigned a, input int unsigned c,
                         input bit w, input bit r);
        bit acc_in, acc_out;
        int unsigned first_dw, last_dw, fb, lb;
        req_valid_i = v;
        req_addr_i  = a;
        req_bytes_i = c[6:0];
        widen_i     = w;
        hdr_ready_i = r;
        #1;
        cmp("R9", "req_ready", req_ready_o, (!m_vld || r) ? 1 : 0);
        acc_out = m_vld && r;
        acc_in  = v && (!m_vld || r);
        if (acc_out) m_tag = (m_tag + 1) % 32;
        if (acc_out) m_vld = 0;
        m_err = 0;
        if (acc_in) begin
            if ((a % 4096) + c > 4096) begin
                m_err = 1;
            end else begin
                first_dw = a / 4;
                last_dw  = (a + c - 1) / 4;
                fb = 0;
                lb = 0;
                for (int b = 0; b < int'(c); b++) begin
                    if ((a + b) / 4 == first_dw) fb |= (1 << ((a + b) % 4));
                    if ((a + b) / 4 == last_dw)  lb |= (1 << ((a + b) % 4));
                end
                m_vld  = 1;
                m_addr = a >> 2;
                m_cnt  = last_dw - first_dw + 1;
                if (w) fb = 15;
                if (m_cnt == 1) lb = 0;
                else if (w) lb = 15;
                m_fbe = fb;
                m_lbe = lb;
            end
        end
        @(posedge clk);
        @(negedge clk);
        check_outputs();
    endtask

    initial begin
        #2000000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        cmp("R11", "hdr_valid", hdr_valid_o, 0);
        cmp("R11", "err_page", err_page_o, 0);
        cmp("R11", "tag", hdr_tag_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4: widened 1 byte at 0x1 -> len 1, address 0, fbe F
        cycle(1, 32'h1, 1, 1, 1);
        // R6: three widened single bytes give identical headers
        cycle(1, 32'h1, 1, 1, 1);
        cycle(1, 32'h2, 1, 1, 1);
        cycle(1, 32'h3, 1, 1, 1);
        cycle(0, 0, 1, 1, 1);
        // R3: exact mode cases
        cycle(1, 32'h1, 1, 0, 1);
        cycle(1, 32'h2, 2, 0, 1);
        cycle(1, 32'h3, 8, 0, 1);
        // R1: 64 bytes at offset 3 -> 17 doublewords
        cycle(1, 32'h1003, 64, 0, 1);
        cycle(1, 32'h2003, 64, 1, 1);
        // R8: crossing and exact-fit at page top
        cycle(1, 32'hFFE, 4, 0, 1);
        cycle(1, 32'hFFC, 4, 0, 1);
        cycle(1, 32'h5FC1, 64, 0, 1);
        cycle(0, 0, 1, 0, 1);
        // R10: stall with pending requests
        cycle(1, 32'h40, 5, 0, 0);
        for (int k = 0; k < 4; k++) cycle(1, 32'h80 + k, 3, 0, 0);
        cycle(1, 32'h90, 6, 0, 1);
        // R7: wrap the tag
        for (int k = 0; k < 40; k++) cycle(1, k * 4, 4, 0, 1);
        // mixed pseudo-random phases
        for (int ph = 0; ph < 8; ph++) begin
            bit w = ph[0];
            cycle(0, 0, 1, w, 1);
            for (int k = 0; k < 400; k++) begin
                int unsigned a = $urandom;
                if ($urandom % 3 == 0) a = (a & 32'hFFFF_F000) | (32'hFC0 + ($urandom % 64));
                cycle(($urandom % 4) != 0, a, 1 + ($urandom % 64), w, ($urandom % 3) != 0);
            end
            cycle(0, 0, 1, w, 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule